// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is a byte-addressed non-volatile memory model that answers as a slave on a two-wire serial bus. It has an on-chip byte array, a page buffer that collects incoming write data, and a timer that stands in for the internal programming cycle. The block watches the bus clock and data lines with the system clock. It answers by pulling the open-drain data line low or letting it go. It never drives the line high.

A host selects the block with a device byte. The host can then set a word address and write one byte or a run of bytes within one page. It can also read from the current address, read from an address it sets with a dummy write, or read a run of bytes. Buffered write data reaches the array only when the host sends a stop. A write cycle then runs for a fixed number of system clocks. During that cycle the block does not acknowledge its device byte, so the host can poll for completion.

A single parameter, `DENSITY_SEL` (0 to 4), sets the array size (128, 256, 512, 1024 or 2048 bytes). It also sets the word-address width (7 to 11 bits), the page size and how many address pins the device byte is compared with. A write-protect input locks the whole array.

Top module: `twowire_eeprom`

## Requirements
- R1: After reset the data line is released (`sda_drive_low_o` = 0) and no write cycle is running.
- R2: The device byte is acknowledged only when its bits 7..4 equal 1010 and its bits 3..1 match the compared pins. Bit 3 matches pin 2, bit 2 matches pin 1 and bit 1 matches pin 0. All three pins are compared for `DENSITY_SEL` 0 and 1. Pins 2 and 1 are compared for 2, only pin 2 for 3, and none for 4. Bit 0 selects a read (1) or a write (0).
- R3: A write sets the word address from the byte after the device byte, and the data bytes that follow are stored there. A dummy write, a repeated start and a read return the stored data.
- R4: During a page write the low page-offset bits of the address advance after each byte and wrap inside the same page. The page size is 8 bytes for `DENSITY_SEL` 0 and 1 and 16 bytes otherwise. No byte outside the page changes.
- R5: A page write may end after any number of bytes up to the page size. Only the locations that received a byte change.
- R6: Buffered write data is committed only at a stop. A start that arrives before the stop discards the buffered bytes and starts no write cycle.
- R7: A committing stop starts a write cycle of `WRITE_CYCLES` system clocks. During this cycle the device byte is not acknowledged, and after it the device byte is acknowledged again.
- R8: While `wp_i` is 1, data bytes are still acknowledged, but nothing is committed at the stop and no write cycle starts.
- R9: A read continues while the host acknowledges each byte. The address advances over the whole array and wraps from the last location to 0. The block releases the line during the host's acknowledge bit.
- R10: A read that sets no address (current-address read) starts at one past the last location accessed. After a page write, that location is the next offset in the same page.
- R11: For densities above 256 bytes, the device-byte bits that are not compared with pins supply the word-address bits above bit 7.
- R12: Incoming bits are taken on the rising edge of the bus clock. The block changes its line drive only after a falling bus-clock edge, a start or a stop, and it releases the line at every stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_drive_low_o | output | 1 | Pull the data line low when 1, release it when 0 |
| pin_addr_i | input | 3 | Hardwired address pins, bit 2 down to bit 0 |
| wp_i | input | 1 | Write protect for the whole array |

## Verification
The bench builds the block with `DENSITY_SEL` = 2. That gives a 512-byte array with 16-byte pages, compares only two address pins, and makes device-byte bit 1 an address bit. Under this setting, the bench can check that pin 0 is ignored, that locations above 255 are reached, and that a sequential read wraps from 511 back to 0. `WRITE_CYCLES` = 600 makes the busy window last for a few address polls. Each poll is then first refused and later accepted, while the bench still runs to its end quickly.

// File: rtl/twe_pkg.sv
package twe_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_ACK_DEV,
    S_WADDR,
    S_ACK_WADDR,
    S_WDATA,
    S_ACK_WDATA,
    S_RDATA,
    S_RACK
  } twe_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  function automatic int unsigned addr_bits(input int unsigned sel);
    return 7 + sel;
  endfunction

  function automatic int unsigned page_bits(input int unsigned sel);
    return (sel < 2) ? 3 : 4;
  endfunction

  // device-byte positions that carry address bits instead of pin matches
  function automatic int unsigned hi_bits(input int unsigned sel);
    return (sel < 2) ? 0 : sel - 1;
  endfunction

endpackage

// File: rtl/twe_bus_sync.sv
module twe_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/twe_write_timer.sv
module twe_write_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/twe_array.sv
module twe_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned PB = 3
) (
  input  logic                        clk_i,
  input  logic                        commit_i,
  input  logic [AW-PB-1:0]            page_i,
  input  logic [(1<<PB)-1:0][7:0]     data_i,
  input  logic [(1<<PB)-1:0]          valid_i,
  input  logic [AW-1:0]               raddr_i,
  output logic [7:0]                  rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PAGE  = 1 << PB;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < PAGE; i++) begin
      if (commit_i && valid_i[i]) mem[{page_i, PB'(i)}] <= data_i[i];
    end
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
  import twe_pkg::*;
#(
  parameter int unsigned DENSITY_SEL  = 1,
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low_o,
  input  logic [2:0] pin_addr_i,
  input  logic       wp_i
);

  localparam int unsigned AW       = addr_bits(DENSITY_SEL);
  localparam int unsigned PB       = page_bits(DENSITY_SEL);
  localparam int unsigned PAGE     = 1 << PB;
  localparam int unsigned HI       = hi_bits(DENSITY_SEL);
  localparam logic [2:0]  PIN_MASK = 3'(3'b111 << HI);

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, commit, dev_ok;
  logic [7:0] rdata;

  twe_state_e              state_q;
  logic [3:0]              bit_cnt_q;
  logic [7:0]              sh_q, tx_q;
  logic [2:0]              dev_hi_q;
  logic [AW-1:0]           addr_q;
  logic                    ack_q, rw_q, drive_q;
  logic [PAGE-1:0][7:0]    buf_q;
  logic [PAGE-1:0]         valid_q;

  twe_bus_sync #(.STAGES(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  twe_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (busy)
  );

  twe_array #(.AW(AW), .PB(PB)) u_array (
    .clk_i    (clk_i),
    .commit_i (commit),
    .page_i   (addr_q[AW-1:PB]),
    .data_i   (buf_q),
    .valid_i  (valid_q),
    .raddr_i  (addr_q),
    .rdata_o  (rdata)
  );

  assign dev_ok = (sh_q[7:4] == DEV_TYPE) &&
                  (((sh_q[3:1] ^ pin_addr_i) & PIN_MASK) == 3'b000) && !busy;
  assign commit = stop_evt && (|valid_q) && !wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      dev_hi_q  <= '0;
      addr_q    <= '0;
      ack_q     <= 1'b0;
      rw_q      <= 1'b0;
      drive_q   <= 1'b0;
      buf_q     <= '0;
      valid_q   <= '0;
    end else if (start_evt) begin
      state_q   <= S_DEV;
      bit_cnt_q <= '0;
      drive_q   <= 1'b0;
      valid_q   <= '0;
    end else if (stop_evt) begin
      state_q   <= S_IDLE;
      drive_q   <= 1'b0;
      valid_q   <= '0;
    end else begin
      case (state_q)
        S_DEV, S_WADDR, S_WDATA: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            sh_q      <= {sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall && bit_cnt_q == 4'd8) begin
            bit_cnt_q <= '0;
            drive_q   <= 1'b1;
            if (state_q == S_DEV) begin
              ack_q    <= dev_ok;
              drive_q  <= dev_ok;
              rw_q     <= sh_q[0];
              dev_hi_q <= sh_q[3:1];
              state_q  <= S_ACK_DEV;
            end else if (state_q == S_WADDR) begin
              addr_q  <= AW'({dev_hi_q, sh_q});
              state_q <= S_ACK_WADDR;
            end else begin
              buf_q[addr_q[PB-1:0]]   <= sh_q;
              valid_q[addr_q[PB-1:0]] <= 1'b1;
              addr_q[PB-1:0]          <= addr_q[PB-1:0] + PB'(1);
              state_q                 <= S_ACK_WDATA;
            end
          end
        end
        S_ACK_DEV: begin
          if (scl_fall) begin
            if (!ack_q) begin
              drive_q <= 1'b0;
              state_q <= S_IDLE;
            end else if (rw_q) begin
              tx_q    <= {rdata[6:0], 1'b0};
              drive_q <= ~rdata[7];
              state_q <= S_RDATA;
            end else begin
              drive_q <= 1'b0;
              state_q <= S_WADDR;
            end
          end
        end
        S_ACK_WADDR, S_ACK_WDATA: begin
          if (scl_fall) begin
            drive_q <= 1'b0;
            state_q <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              drive_q   <= 1'b0;
              addr_q    <= addr_q + AW'(1);
              state_q   <= S_RACK;
            end else begin
              drive_q <= ~tx_q[7];
              tx_q    <= {tx_q[6:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            ack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              tx_q    <= {rdata[6:0], 1'b0};
              drive_q <= ~rdata[7];
              state_q <= S_RDATA;
            end else begin
              drive_q <= 1'b0;
              state_q <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_drive_low_o = drive_q;

endmodule

// File: rtl/twe_checker.sv
module twe_checker
  import twe_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_drive_low_o,
  input logic       scl_fall,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       busy,
  input logic       wp_i,
  input twe_state_e state_q
);

  p_release_at_stop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_drive_low_o);

  p_drive_on_fall_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_drive_low_o) |-> $past(scl_fall || start_evt || stop_evt));

  p_commit_at_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_evt));

  p_protect_blocks_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(!wp_i));

  p_busy_nack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ACK_DEV && busy) |-> !sda_drive_low_o);

  p_host_ack_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RACK) |-> !sda_drive_low_o);

endmodule

bind twowire_eeprom twe_checker u_twe_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sda_drive_low_o (sda_drive_low_o),
  .scl_fall        (scl_fall),
  .start_evt       (start_evt),
  .stop_evt        (stop_evt),
  .busy            (busy),
  .wp_i            (wp_i),
  .state_q         (state_q)
);

// File: tb/twowire_eeprom_bench.sv
`timescale 1ns/1ps
module twowire_eeprom_bench;

  localparam int SEL   = 2;
  localparam int DEPTH = 512;
  localparam int PG    = 16;
  localparam int WCYC  = 600;
  localparam int Q     = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] pins = 3'b010;
  logic sda_drv, sda_line;
  assign sda_line = sda_m & ~sda_drv;

  always #2 clk = ~clk;

  twowire_eeprom #(.DENSITY_SEL(SEL), .WRITE_CYCLES(WCYC)) u_twowire_eeprom (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low_o(sda_drv), .pin_addr_i(pins), .wp_i(wp));

  int total = 0, bad = 0, exp_ptr = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [DEPTH];
  bit exp_known [DEPTH];
  logic [7:0] wbuf [PG];
  logic [7:0] rbuf [20];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic s);
    sda_m = b; waitq(Q);
    scl = 1'b1; waitq(Q);
    s = sda_line; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic start_c();
    sda_m = 1'b1; waitq(Q);
    scl = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; waitq(Q);
    scl = 1'b1; waitq(Q);
    sda_m = 1'b1; waitq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit more);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(!more, s);
  endtask

  function automatic logic [7:0] dev_byte(input int a, input bit rd);
    return {4'b1010, pins[2:1], 1'(a >> 8), rd};
  endfunction

  function automatic int page_slot(input int base, input int k);
    return (base & ~(PG - 1)) | ((base + k) & (PG - 1));
  endfunction

  function automatic void model_write(input int addr, input int n);
    if (!wp) begin
      for (int k = 0; k < n; k++) begin
        exp_mem[page_slot(addr, k)] = wbuf[k];
        exp_known[page_slot(addr, k)] = 1'b1;
      end
    end
    exp_ptr = (n > 0) ? page_slot(addr, n) : addr;
  endfunction

  task automatic page_write(input int addr, input int n, output bit all_ack);
    bit a;
    all_ack = 1'b1;
    start_c();
    send_byte(dev_byte(addr, 1'b0), a); all_ack &= a;
    send_byte(8'(addr), a); all_ack &= a;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); all_ack &= a;
    end
    stop_c();
    model_write(addr, n);
  endtask

  task automatic wait_ready(output int polls);
    bit a;
    polls = 0;
    do begin
      start_c();
      send_byte(dev_byte(0, 1'b0), a);
      stop_c();
      polls++;
    end while (!a && polls < 20);
  endtask

  task automatic rand_read(input int addr, input int n);
    bit a;
    start_c();
    send_byte(dev_byte(addr, 1'b0), a);
    send_byte(8'(addr), a);
    start_c();
    send_byte(dev_byte(0, 1'b1), a);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    stop_c();
    exp_ptr = (addr + n) % DEPTH;
  endtask

  task automatic cur_read(input int n);
    bit a;
    start_c();
    send_byte(dev_byte(0, 1'b1), a);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    stop_c();
    exp_ptr = (exp_ptr + n) % DEPTH;
  endtask

  task automatic check_read(input int addr, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (addr + k) % DEPTH;
      if (exp_known[a]) chk(rbuf[k] == exp_mem[a], req, rbuf[k], exp_mem[a]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    int polls;
    void'($urandom(32'd7));
    for (int i = 0; i < DEPTH; i++) exp_known[i] = 1'b0;

    // R1: reset state
    waitq(5);
    chk(sda_drv == 1'b0, "R1 released in reset", sda_drv, 0);
    rst_n = 1'b1; waitq(5);
    chk(sda_drv == 1'b0, "R1 released after reset", sda_drv, 0);
    start_c(); send_byte(dev_byte(0, 1'b0), ack); stop_c();
    chk(ack, "R1 no write cycle after reset", ack, 1);

    // R2: device byte matching
    start_c(); send_byte(8'b1011_0100, ack); stop_c();
    chk(!ack, "R2 wrong type code", ack, 0);
    start_c(); send_byte({4'b1010, pins[2], ~pins[1], 2'b00}, ack); stop_c();
    chk(!ack, "R2 pin 1 mismatch", ack, 0);
    start_c(); send_byte({4'b1010, ~pins[2], pins[1], 2'b00}, ack); stop_c();
    chk(!ack, "R2 pin 2 mismatch", ack, 0);
    pins[0] = 1'b1;
    start_c(); send_byte(dev_byte(0, 1'b0), ack); stop_c();
    chk(ack, "R2 pin 0 not compared", ack, 1);
    chk(sda_drv == 1'b0, "R12 released after stop", sda_drv, 0);

    // R3, R7, R11, R10
    wbuf[0] = 8'h5C; wbuf[1] = 8'h7E;
    page_write(12'h0A3, 2, ack);
    chk(ack, "R3 write acknowledged", ack, 1);
    wait_ready(polls);
    chk(polls > 1, "R7 busy refuses first poll", polls, 2);
    chk(polls < 20, "R7 ready after write cycle", polls, 3);
    wbuf[0] = 8'hC5;
    page_write(12'h1A3, 1, ack);
    wait_ready(polls);
    rand_read(12'h0A3, 1);
    check_read(12'h0A3, 1, "R3 random read");
    cur_read(1);
    check_read(12'h0A4, 1, "R10 current address read");
    rand_read(12'h1A3, 1);
    check_read(12'h1A3, 1, "R11 upper address bit");
    chk(sda_drv == 1'b0, "R12 released after read", sda_drv, 0);

    // R4: wrap inside page
    wbuf[0] = 8'hAA;
    page_write(12'h140, 1, ack); wait_ready(polls);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
    page_write(12'h13E, 4, ack); wait_ready(polls);
    cur_read(1);
    check_read(12'h132, 1, "R10 pointer after page wrap");
    rand_read(12'h13E, 2); check_read(12'h13E, 2, "R4 page tail");
    rand_read(12'h130, 2); check_read(12'h130, 2, "R4 wrapped to page start");
    rand_read(12'h140, 1); check_read(12'h140, 1, "R4 next page untouched");

    // R5: partial page
    for (int k = 0; k < PG; k++) wbuf[k] = 8'(8'h30 + k);
    page_write(12'h060, PG, ack); wait_ready(polls);
    wbuf[0] = 8'hE0; wbuf[1] = 8'hE1; wbuf[2] = 8'hE2;
    page_write(12'h064, 3, ack); wait_ready(polls);
    rand_read(12'h060, PG); check_read(12'h060, PG, "R5 partial page");

    // R6: start before stop discards
    start_c();
    send_byte(dev_byte(12'h060, 1'b0), ack);
    send_byte(8'h60, ack);
    send_byte(8'h11, ack);
    start_c(); stop_c();
    wait_ready(polls);
    chk(polls == 1, "R6 no write cycle after restart", polls, 1);
    rand_read(12'h060, 1); check_read(12'h060, 1, "R6 data unchanged");

    // R8: write protect
    wp = 1'b1;
    wbuf[0] = 8'h99; wbuf[1] = 8'h98;
    page_write(12'h061, 2, ack);
    chk(ack, "R8 protected data acknowledged", ack, 1);
    wait_ready(polls);
    chk(polls == 1, "R8 no write cycle", polls, 1);
    wp = 1'b0;
    rand_read(12'h061, 2); check_read(12'h061, 2, "R8 data unchanged");

    // R9: sequential read wraps at array end
    wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
    page_write(12'h1FE, 2, ack); wait_ready(polls);
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    page_write(12'h000, 2, ack); wait_ready(polls);
    rand_read(12'h1FE, 4); check_read(12'h1FE, 4, "R9 sequential wrap");
    chk(sda_drv == 1'b0, "R12 released after sequential read", sda_drv, 0);

    // random page writes
    for (int it = 0; it < 6; it++) begin
      int addr, n, p;
      addr = int'($urandom % DEPTH);
      n = 1 + int'($urandom % PG);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      page_write(addr, n, ack);
      chk(ack, "R3 random write acknowledged", ack, 1);
      wait_ready(polls);
      chk(polls > 1 && polls < 20, "R7 random write cycle", polls, 3);
      p = exp_ptr;
      cur_read(1);
      check_read(p, 1, "R10 random current read");
      rand_read(addr & ~(PG - 1), PG);
      check_read(addr & ~(PG - 1), PG, "R5 random page contents");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule